// File: doc/BRIEF.md
# UART Receive Pop Buffer

A small circular byte store between a UART deserializer and a register interface. The deserializer offers bytes on a push strobe. Each byte is written at the slot that lies `count` places after the read head, wrapping at the buffer depth. The buffer reports to the deserializer how many slots are free, but only while reception is switched on. When reception is off it reports zero.

On the register side, the data read port always shows the byte at the read head. A bus read whose address matches the data register pops that byte. The pop happens only when reception is on and the buffer holds at least one byte. A one-cycle ready pulse tells the event logic that a byte is waiting. The pulse fires after every accepted arrival, and again after a pop that leaves bytes behind.

Top module: `uart_rx_pop_buffer`

## Requirements
- R1: `rd_data` always equals the byte stored at the read head, also when the buffer is empty; slots are zero after reset.
- R2: A pop happens when `rd_en` is high, `rd_addr` equals `DATA_ADDR` (default 0), reception is on, and the buffer is non-empty. A pop moves the head forward by one, wrapping from DEPTH-1 to 0, and lowers the count by one.
- R3: A read with `rd_en` low, a read to any address other than `DATA_ADDR`, or a read while reception is off changes neither the head nor the count.
- R4: An accepted byte is written at slot (head + count) mod DEPTH and raises the count by one.
- R5: A byte pushed while the count equals DEPTH is dropped and never appears on `rd_data`.
- R6: `free_slots` equals DEPTH minus count while reception is on, and 0 while it is off.
- R7: `rdy_evt` is high for exactly the one cycle after an accepted push.
- R8: `rdy_evt` is high in the cycle after a pop that leaves at least one byte. It stays low after a pop that empties the buffer, unless a byte was accepted in the same cycle.
- R9: An accepted push and a pop in the same cycle leave the count unchanged.
- R10: Reset sets the head, the count and the reception flag to zero, and `rdy_evt` low.
- R11: `rx_start` turns reception on and `rx_stop` turns it off; when both are high, `rx_stop` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_start | input | 1 | Turn reception on |
| rx_stop | input | 1 | Turn reception off |
| push_valid | input | 1 | Deserializer offers a byte |
| push_data | input | DW | Offered byte |
| rd_en | input | 1 | One-cycle bus read strobe |
| rd_addr | input | AW | Bus read address |
| rd_data | output | DW | Byte at the read head |
| free_slots | output | CNT_W | Free slots reported to the deserializer |
| rdy_evt | output | 1 | One-cycle ready pulse |

## Verification
A wrong head pointer shows on `rd_data` in the very next cycle, because the port reads the head slot directly. A wrong count first shows on `free_slots` one cycle after the faulty update, while reception is on. If reception is off, a wrong count stays hidden until the data order breaks after a wrap, or until a ready pulse appears or is missing after a pop. Overflow and wrap errors surface as a byte out of sequence on the pops that follow.

// File: rtl/uart_rx_pop_buffer.sv
module uart_rx_pop_buffer #(
  parameter int DEPTH     = 6,
  parameter int DW        = 8,
  parameter int AW        = 4,
  parameter int DATA_ADDR = 0,
  localparam int PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_start,
  input  logic             rx_stop,
  input  logic             push_valid,
  input  logic [DW-1:0]    push_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  output logic [CNT_W-1:0] free_slots,
  output logic             rdy_evt
);
  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] head, tail, head_nxt;
  logic [CNT_W-1:0] count;
  logic [CNT_W:0]   tail_sum;
  logic             started;

  wire full = (count == CNT_W'(DEPTH));
  wire push = push_valid && !full;
  wire pop  = rd_en && (rd_addr == AW'(DATA_ADDR)) && started && (count != '0);

  always_comb begin
    tail_sum = (CNT_W+1)'(head) + (CNT_W+1)'(count);
    if (tail_sum >= (CNT_W+1)'(DEPTH)) tail_sum = tail_sum - (CNT_W+1)'(DEPTH);
    tail = tail_sum[PTR_W-1:0];
  end

  assign head_nxt   = (head == PTR_W'(DEPTH - 1)) ? '0 : head + 1'b1;
  assign rd_data    = mem[head];
  assign free_slots = started ? CNT_W'(DEPTH) - count : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head    <= '0;
      count   <= '0;
      started <= 1'b0;
      rdy_evt <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (rx_stop)       started <= 1'b0;
      else if (rx_start) started <= 1'b1;
      if (push) mem[tail] <= push_data;
      if (pop)  head <= head_nxt;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      rdy_evt <= push || (pop && count > CNT_W'(1));
    end
  end
endmodule

module uart_rx_pop_buffer_chk #(
  parameter int DEPTH = 6,
  parameter int PTR_W = 3,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_stop,
  input logic             push_valid,
  input logic             pop,
  input logic             started,
  input logic [PTR_W-1:0] head,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] free_slots,
  input logic             rdy_evt
);
  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  // R7
  push_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && count < CNT_W'(DEPTH)) |=> rdy_evt);
  // R11
  stop_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stop |=> (free_slots == '0));
  // R3
  idle_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !started |=> $stable(head));
  // R9
  both_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && push_valid && count < CNT_W'(DEPTH)) |=> $stable(count));
  // R2
  pop_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && head == PTR_W'(DEPTH - 1)) |=> (head == '0));
endmodule

bind uart_rx_pop_buffer uart_rx_pop_buffer_chk #(
  .DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_stop(rx_stop), .push_valid(push_valid),
  .pop(pop), .started(started), .head(head), .count(count),
  .free_slots(free_slots), .rdy_evt(rdy_evt)
);

// File: tb/uart_rx_pop_buffer_tb.sv
module uart_rx_pop_buffer_tb;
  localparam int DEPTH = 6;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic rx_start = 0, rx_stop = 0, push_valid = 0, rd_en = 0;
  logic [7:0] push_data = 0;
  logic [3:0] rd_addr = 0;
  logic [7:0] rd_data;
  logic [CW-1:0] free_slots;
  logic rdy_evt;

  always #10 clk = ~clk;

  uart_rx_pop_buffer #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .rx_stop(rx_stop),
    .push_valid(push_valid), .push_data(push_data), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .free_slots(free_slots),
    .rdy_evt(rdy_evt)
  );

  int tests = 0, fails = 0;
  logic [7:0] m_mem [DEPTH];
  int m_head, m_count;
  bit m_started, m_evt;

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_free();
    return m_started ? DEPTH - m_count : 0;
  endfunction

  task automatic model_reset();
    m_head = 0; m_count = 0; m_started = 0; m_evt = 0;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 0;
  endtask

  task automatic cyc(bit st, bit sp, bit pv, logic [7:0] pd, bit re, logic [3:0] ra);
    bit do_push, do_pop;
    rx_start = st; rx_stop = sp; push_valid = pv; push_data = pd; rd_en = re; rd_addr = ra;
    do_push = pv && (m_count < DEPTH);
    do_pop  = re && (ra == 0) && m_started && (m_count > 0);
    @(posedge clk);
    if (do_push) m_mem[(m_head + m_count) % DEPTH] = pd;
    m_evt = do_push || (do_pop && m_count > 1);
    if (do_pop) m_head = (m_head + 1) % DEPTH;
    m_count = m_count + int'(do_push) - int'(do_pop);
    if (sp) m_started = 0; else if (st) m_started = 1;
    @(negedge clk);
    rx_start = 0; rx_stop = 0; push_valid = 0; rd_en = 0;
    chk("R1 rd_data", rd_data, m_mem[m_head]);
    chk("R6 free_slots", free_slots, exp_free());
    chk("R7/R8 rdy_evt", rdy_evt, m_evt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: reset state
    chk("R10 free", free_slots, 0);
    chk("R10 evt", rdy_evt, 0);
    chk("R10 data", rd_data, 0);
    // R3: read while stopped does not pop
    cyc(0, 0, 1, 8'hA1, 0, 0);
    cyc(0, 0, 0, 0, 1, 0);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R3 stopped read kept byte", free_slots, DEPTH - 1);
    // R3: wrong address does not pop
    cyc(0, 0, 0, 0, 1, 4'h3);
    chk("R3 wrong addr", free_slots, DEPTH - 1);
    // R2: real pop empties, no ready pulse (R8)
    cyc(0, 0, 0, 0, 1, 0);
    chk("R2 pop", free_slots, DEPTH);
    chk("R8 last pop no evt", rdy_evt, 0);
    // R1: empty read shows stale head slot, no pop
    cyc(0, 0, 0, 0, 1, 0);
    chk("R1 empty read", free_slots, DEPTH);
    // R4/R5: fill past full
    for (int i = 0; i < DEPTH + 2; i++) cyc(0, 0, 1, 8'h10 + 8'(i), 0, 0);
    chk("R5 full", free_slots, 0);
    chk("R4 first stored", rd_data, 8'h10);
    // R9: push and pop together when not full
    cyc(0, 0, 0, 0, 1, 0);
    cyc(0, 0, 1, 8'h77, 1, 0);
    chk("R9 count kept", free_slots, 1);
    // R5: dropped bytes never show; drain and check order
    for (int i = 0; i < DEPTH; i++) cyc(0, 0, 0, 0, 1, 0);
    chk("R5 drained", free_slots, DEPTH);
    // R11: stop wins over start
    cyc(1, 1, 0, 0, 0, 0);
    chk("R11 stop wins", free_slots, 0);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R11 start", free_slots, DEPTH);
    // random phase
    void'($urandom(32'h5EED1234));
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      cyc(r < 3, r > 96, $urandom_range(0, 99) < 45, 8'($urandom),
          $urandom_range(0, 99) < 45, ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0);
    end
    // R10: mid-run reset
    rst_n = 0;
    @(posedge clk);
    model_reset();
    @(negedge clk);
    rst_n = 1;
    chk("R10 reset free", free_slots, 0);
    chk("R10 reset evt", rdy_evt, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule